// File: doc/BRIEF.md
# Protected Management RAM Access Decoder

This block sits inside a memory controller, in front of the memory arrays. For every bus access it decides whether the access reaches the protected management RAM or normal system memory. Each access brings an address, an identifier for the bus master making it, and a valid strobe. The CPU's management-mode indication feeds the decision, along with two software controls. The first is an open control, which lets boot code fill the protected RAM before the first management interrupt. The second is an overlay bypass, which lets the management handler reach the system memory that sits under the protected window.

A lock bit freezes the open control in place so that later software cannot reopen the window. The block drives one chip select for each memory and a denied flag. The flag marks a non-CPU master that addressed the window while it was open. All three outputs are registered, so they are valid one cycle after the access is presented.

Top module: `smram_gate`

## Requirements
- R1: A valid CPU access (master identifier equal to `CPU_ID`, default 0) inside the window while `smiActive` is high and `bypassEn` is low asserts `selProt` on the next cycle.
- R2: The window runs from `WIN_BASE` to `WIN_LAST` inclusive (defaults 0x38000 and 0x3FFFF). A valid access at any address outside that range asserts `selSys` and never `selProt` or `denied`.
- R3: A valid CPU access inside the window with `smiActive` low and the open control clear asserts `selSys` and does not assert `denied`.
- R4: A pulse on `openSet` opens the window from the next cycle. While the window is open, a CPU access inside it asserts `selProt` with `smiActive` low. A pulse on `openClr` closes the window, and when both pulses arrive in the same cycle the clear wins.
- R5: A valid access from any master other than `CPU_ID` inside the window asserts `selSys`, never `selProt`. It asserts `denied` only while the open control is set.
- R6: While `smiActive` and `bypassEn` are both high, a CPU access inside the window asserts `selSys`. With `smiActive` low, `bypassEn` has no effect.
- R7: The outputs are registered one cycle after the access. At most one of `selProt` and `selSys` is high. `denied` only appears together with `selSys`. A cycle with `addrValid` low gives all three outputs low on the next cycle.
- R8: Reset clears the open control, the lock and all three outputs.
- R9: A pulse on `lockSet` sets the lock from the next cycle. Once the lock is set, `openSet` is ignored until reset, while `openClr` still works. Setting the lock leaves an already open window open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | An access is presented this cycle |
| addr | input | AW | Access byte address |
| masterId | input | MW | Identifier of the master making the access |
| smiActive | input | 1 | CPU is in management mode |
| bypassEn | input | 1 | Route CPU window accesses to the underlying system memory during management mode |
| openSet | input | 1 | Pulse: open the window for initialization |
| openClr | input | 1 | Pulse: close the window |
| lockSet | input | 1 | Pulse: lock the open control against further setting |
| selProt | output | 1 | Chip select for the protected RAM |
| selSys | output | 1 | Chip select for system memory |
| denied | output | 1 | Non-CPU master hit the open window |

## Verification
The bench drives the addresses on each side of both window edges. A comparison that is off by one moves either 0x37FFF or 0x3FFFF to the wrong memory. It sends a DMA master into the window both during management mode and with the window open. A decoder that checked only the address would hand DMA the protected RAM, and a wrong deny term would flag the wrong cases. It asserts bypass with and without management mode, opens and clears the window in the same cycle, and sets the lock both before and after opening. A lock that failed to hold would let the window open again, and a lock that cleared the open control would cut off initialization early. A reset in mid-run must clear the lock, or the window could never be opened again.

// File: rtl/smram_pkg.sv
package smram_pkg;

  // Routing decision handed from control to datapath each cycle.
  typedef struct packed {
    logic prot;
    logic sys;
    logic deny;
  } route_t;

endpackage

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_pkg::*;
#(
  parameter int MW = 3,
  parameter logic [MW-1:0] CPU_ID = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          openSet,
  input  logic          openClr,
  input  logic          lockSet,
  input  logic          addrValid,
  input  logic          inWin,
  input  logic [MW-1:0] masterId,
  input  logic          smiActive,
  input  logic          bypassEn,
  output route_t        route,
  output logic          openState,
  output logic          lockState
);

  logic isCpu;
  logic cpuMayEnter;

  // Open control and its lock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      openState <= 1'b0;
      lockState <= 1'b0;
    end else begin
      if (lockSet) lockState <= 1'b1;
      if (openClr) openState <= 1'b0;
      else if (openSet && !lockState) openState <= 1'b1;
    end
  end

  assign isCpu       = (masterId == CPU_ID);
  assign cpuMayEnter = (smiActive && !bypassEn) || (!smiActive && openState);

  always_comb begin
    route = '0;
    if (addrValid) begin
      if (inWin && isCpu && cpuMayEnter) begin
        route.prot = 1'b1;
      end else begin
        route.sys  = 1'b1;
        route.deny = inWin && !isCpu && openState;
      end
    end
  end

  assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lockState && !openState) |=> !openState);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> lockState);

  assert_open_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (openState && !openClr) |=> openState);

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    openClr |=> !openState);

endmodule

// File: rtl/smram_dp.sv
module smram_dp
  import smram_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_BASE = AW'('h38000),
  parameter logic [AW-1:0] WIN_LAST = AW'('h3FFFF)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  route_t        route,
  output logic          inWin,
  output logic          selProt,
  output logic          selSys,
  output logic          denied
);

  assign inWin = (addr >= WIN_BASE) && (addr <= WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selProt <= 1'b0;
      selSys  <= 1'b0;
      denied  <= 1'b0;
    end else begin
      selProt <= route.prot;
      selSys  <= route.sys;
      denied  <= route.deny;
    end
  end

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selProt, selSys}));

  assert_deny_with_sys_R7: assert property (@(posedge clk) disable iff (!rstN)
    denied |-> selSys);

endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smram_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 3,
  parameter logic [MW-1:0] CPU_ID = '0,
  parameter logic [AW-1:0] WIN_BASE = AW'('h38000),
  parameter logic [AW-1:0] WIN_LAST = AW'('h3FFFF)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrValid,
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] masterId,
  input  logic          smiActive,
  input  logic          bypassEn,
  input  logic          openSet,
  input  logic          openClr,
  input  logic          lockSet,
  output logic          selProt,
  output logic          selSys,
  output logic          denied
);

  route_t route;
  logic   inWin;
  logic   openState;
  logic   lockState;

  smram_ctrl #(.MW(MW), .CPU_ID(CPU_ID)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .openSet(openSet), .openClr(openClr), .lockSet(lockSet),
    .addrValid(addrValid), .inWin(inWin), .masterId(masterId),
    .smiActive(smiActive), .bypassEn(bypassEn),
    .route(route), .openState(openState), .lockState(lockState)
  );

  smram_dp #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) i_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .route(route),
    .inWin(inWin), .selProt(selProt), .selSys(selSys), .denied(denied)
  );

  assert_dma_never_prot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && masterId != CPU_ID) |=> !selProt);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (!selProt && !selSys && !denied));

  assert_outside_sys_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !inWin) |=> (selSys && !denied));

  assert_closed_no_prot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !smiActive && !openState) |=> !selProt);

  assert_smi_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && inWin && masterId == CPU_ID && smiActive && !bypassEn) |=> selProt);

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> (!selProt && !selSys && !denied && !openState && !lockState));

endmodule

// File: tb/test_smram_gate.sv
module test_smram_gate;

  localparam int AW = 32;
  localparam int MW = 3;

  typedef struct {
    logic  prot;
    logic  sys;
    logic  deny;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          addrValid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [MW-1:0] masterId = '0;
  logic          smiActive = 1'b0;
  logic          bypassEn = 1'b0;
  logic          openSet = 1'b0;
  logic          openClr = 1'b0;
  logic          lockSet = 1'b0;
  logic          selProt, selSys, denied;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  item_t expQ[$];

  always #10 clk = ~clk;

  smram_gate i_smram_gate (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addr(addr),
    .masterId(masterId), .smiActive(smiActive), .bypassEn(bypassEn),
    .openSet(openSet), .openClr(openClr), .lockSet(lockSet),
    .selProt(selProt), .selSys(selSys), .denied(denied)
  );

  // Monitor: compare registered outputs 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (rstN && expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      checks++;
      if ({selProt, selSys, denied} !== {e.prot, e.sys, e.deny}) begin
        errors++;
        $display("FAIL %s: prot/sys/deny got %b%b%b expected %b%b%b",
                 e.tag, selProt, selSys, denied, e.prot, e.sys, e.deny);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic access(input logic [AW-1:0] a, input logic [MW-1:0] id,
                        input logic smi, input logic byp,
                        input logic ep, input logic es, input logic ed,
                        input string tag);
    item_t e;
    @(negedge clk);
    addrValid = 1'b1; addr = a; masterId = id; smiActive = smi; bypassEn = byp;
    openSet = 1'b0; openClr = 1'b0; lockSet = 1'b0;
    e.prot = ep; e.sys = es; e.deny = ed; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic ctrl(input logic os, input logic oc, input logic ls, input string tag);
    item_t e;
    @(negedge clk);
    addrValid = 1'b0; smiActive = 1'b0; bypassEn = 1'b0;
    openSet = os; openClr = oc; lockSet = ls;
    e.prot = 1'b0; e.sys = 1'b0; e.deny = 1'b0; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic doReset();
    @(negedge clk);
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    addrValid = 1'b0; openSet = 1'b0; openClr = 1'b0; lockSet = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({selProt, selSys, denied} !== 3'b000) begin
      errors++;
      $display("FAIL R8: outputs in reset got %b%b%b expected 000", selProt, selSys, denied);
    end
    rstN = 1'b1;

    // R8/R3: open control is clear after reset, CPU outside SMM goes to system memory
    access(32'h38000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 R3 closed after reset");
    // R1 and R2 boundaries
    access(32'h38000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1 R2 low edge smi");
    access(32'h3FFFF, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2 high edge smi");
    access(32'h37FFF, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 below window");
    access(32'h40000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 above window");
    access(32'h00000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 address zero");
    // R5: DMA in window during SMM, window closed
    access(32'h3C000, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5 dma smi closed");
    // R7: idle cycle
    ctrl(1'b0, 1'b0, 1'b0, "R7 idle cycle");
    // R6: bypass during SMM
    access(32'h3A000, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6 bypass in smi");
    // R4: open window
    ctrl(1'b1, 1'b0, 1'b0, "R4 open pulse");
    access(32'h38000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 open cpu reaches prot");
    access(32'h3FFFF, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 bypass ignored outside smi");
    access(32'h39000, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 dma open denied");
    access(32'h39000, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R5 dma open smi denied");
    access(32'h50000, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 dma outside open");
    access(32'h37FFF, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 open below window");
    // R4: simultaneous set and clear -> clear wins
    ctrl(1'b1, 1'b1, 1'b0, "R4 set and clear");
    access(32'h38000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 clear wins");
    access(32'h39000, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 dma closed no deny");
    // R9: lock while closed
    ctrl(1'b0, 1'b0, 1'b1, "R9 lock pulse");
    ctrl(1'b1, 1'b0, 1'b0, "R9 open after lock");
    access(32'h38000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 open ignored when locked");
    access(32'h38000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 smi still reaches prot");

    // R9/R8: reset clears lock
    doReset();
    ctrl(1'b1, 1'b0, 1'b0, "R8 open after reset");
    access(32'h3F000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 lock cleared by reset");
    // R9: lock while open keeps window open, clear still works, reopen blocked
    ctrl(1'b0, 1'b0, 1'b1, "R9 lock while open");
    access(32'h3F000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 stays open after lock");
    ctrl(1'b0, 1'b1, 1'b0, "R9 clear under lock");
    access(32'h3F000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 clear works under lock");
    ctrl(1'b1, 1'b0, 1'b0, "R9 reopen attempt");
    access(32'h3F000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 reopen blocked");
    ctrl(1'b0, 1'b0, 1'b0, "R7 final idle");

    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule